// File: doc/BRIEF.md
# Framebuffer Scanout Pixel Reader

This block streams a true-colour frame from memory into a display pipeline. Software writes a frame base address and sets an enable bit through a small register window. At each frame boundary the block takes a snapshot of both. While a frame is running, it fetches the frame as fixed-length bursts of wide memory words. Before it issues a burst, it reserves room for that burst in a local prefetch FIFO. This means the memory side never needs backpressure on read data.

Each wide word carries several 32-bit pixels. Only the lower 24 bits of a pixel hold colour: red in the third byte, green in the second and blue in the lowest. The top byte is padding. Pixels leave on a valid/ready stream, one per accepted cycle, with a start-of-frame mark and an end-of-line mark. A reduced 5-6-5 colour word for a 16-bit resistor-ladder DAC leaves alongside each pixel.

The display timing logic supplies `pix_ready` during the active picture. If a pixel is demanded before its data has arrived, the block outputs black and records the event in a sticky status flag. It still advances its screen position, so later pixels stay aligned. Elaboration rejects the following configurations:
- a memory word narrower than 32 bits;
- a memory word that is not a multiple of 32 bits;
- a channel depth other than 8 bits;
- a frame whose size does not divide into whole bursts.

Top module: `fbscan_top`

## Requirements
- R1: After reset, `pix_valid` and `mem_req_valid` are 0, and the control and status registers read 0.
- R2: Pixel p of a frame (p = line*FRAME_W + column) is the 32-bit value stored at byte address base + 4*p. Within one memory word, the bits 31:0 slot is emitted first, followed by the higher slots in ascending order. `pix_data` carries that value unchanged, including the padding byte.
- R3: `pix_rgb565` equals {pix_data[23:19], pix_data[15:10], pix_data[7:3]}: red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R4: `pix_sof` is 1 only with pixel 0 of line 0. `pix_eol` is 1 only with column FRAME_W-1 of every line. One pixel is accepted in each cycle where `pix_valid` and `pix_ready` are both 1.
- R5: Each memory request covers BURST_WORDS words. Within a frame, request k has address base + k*BURST_WORDS*MEM_W/8. An unaccepted request stays asserted with a stable address. Read data never arrives while the FIFO holds FIFO_WORDS words.
- R6: After line FRAME_H-1 the next frame reads again from the base. The base and enable are sampled only when a frame starts. A base written mid-frame first applies to the next frame.
- R7: If `pix_ready` is 1 and the pixel's data has not arrived, the block outputs 0 on `pix_data` and `pix_rgb565` and sets the sticky underflow flag. The screen position still advances, and every later pixel keeps the value that R2 assigns to its position.
- R8: The register window uses 7-bit byte offsets:
  - 0x00: control, bit 0 enable.
  - 0x04: 32-bit frame base.
  - 0x08: status, with the current line in bits 15:0, active in bit 16 and sticky underflow in bit 17. Writing a 1 to bit 17 at 0x08 clears the underflow flag.
- R9: If enable is cleared mid-frame, the current frame still completes. After that, `pix_valid` stays 0, no memory request is issued and the active flag reads 0 until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req_valid | output | 1 | Burst read request valid |
| mem_req_ready | input | 1 | Burst read request accepted |
| mem_req_addr | output | 32 | Byte address of the first word of the burst |
| mem_rsp_valid | input | 1 | Read data word valid |
| mem_rsp_data | input | MEM_W | Read data word |
| pix_valid | output | 1 | Pixel stream valid (frame running) |
| pix_ready | input | 1 | Display pipeline takes a pixel |
| pix_data | output | 32 | Packed pixel, padding:R:G:B |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of a line |
| pix_rgb565 | output | 16 | Reduced colour for the DAC |

## Verification
An underflow black pixel and the discard of a late-arriving word can occur in the same cycle. The skip count is then raised and lowered at once, and a mistake there shifts every later pixel. The bench provokes this by holding back memory responses mid-line while `pix_ready` stays high, and then releasing them. It judges the result by requiring that every non-black pixel, in the rest of that frame and in the following frames, matches the value computed from its address. A second collision, a base-register write during a running frame, is judged by the request addresses and pixel values of the current and next frames.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

    localparam int PIX_BITS = 32;

    localparam logic [6:0] OFS_CTRL = 7'h00;
    localparam logic [6:0] OFS_BASE = 7'h04;
    localparam logic [6:0] OFS_STAT = 7'h08;

    localparam int STAT_ACTIVE_BIT = 16;
    localparam int STAT_UFLOW_BIT  = 17;

    typedef enum logic {
        FR_WAIT = 1'b0,
        FR_RUN  = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic        en;
        logic [31:0] base;
    } scan_cfg_t;

    typedef struct packed {
        logic [PIX_BITS-1:0] px;
        logic                sof;
        logic                eol;
    } pix_beat_t;

    // keep the top bits of each 8-bit channel: 5 red, 6 green, 5 blue
    function automatic logic [15:0] to_rgb565(input logic [PIX_BITS-1:0] p);
        return {p[23:19], p[15:10], p[7:3]};
    endfunction

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
    import fbscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output scan_cfg_t   cfg,
    input  logic        uflow,
    input  logic [15:0] line,
    input  logic        active
);

    logic sticky;
    logic clr_sticky;

    assign clr_sticky = we && (addr == OFS_STAT) && wdata[STAT_UFLOW_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            sticky <= 1'b0;
        end else begin
            if (we && addr == OFS_CTRL) cfg.en   <= wdata[0];
            if (we && addr == OFS_BASE) cfg.base <= wdata;
            // a new underflow wins over a simultaneous clear
            if (uflow)           sticky <= 1'b1;
            else if (clr_sticky) sticky <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = {31'b0, cfg.en};
            OFS_BASE: rdata = cfg.base;
            OFS_STAT: rdata = {14'b0, sticky, active, line};
            default:  rdata = '0;
        endcase
    end

    // R7: an underflow reported by the emitter is always recorded
    a_r7_sticky_set: assert property (@(posedge clk) disable iff (rst)
        uflow |=> sticky);

endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
    parameter int MEM_W       = 128,
    parameter int BURST       = 8,
    parameter int DEPTH       = 16,
    parameter int TOTAL_WORDS = 120000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [31:0]      base_in,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    input  logic             rsp_valid,
    input  logic [MEM_W-1:0] rsp_data,
    input  logic             pop,
    output logic [MEM_W-1:0] head,
    output logic             avail,
    output logic             quiet
);

    localparam int WORD_BYTES = MEM_W / 8;
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(TOTAL_WORDS + 1);

    logic [MEM_W-1:0] store [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt, resv;
    logic [IW-1:0]    issued;
    logic [31:0]      base_q;
    logic             req_acc;

    assign req_valid = (issued != IW'(TOTAL_WORDS)) && (32'(resv) + BURST <= DEPTH);
    assign req_addr  = base_q + 32'(issued) * WORD_BYTES;
    assign req_acc   = req_valid && req_ready;
    assign head      = store[rp];
    assign avail     = (cnt != '0);
    assign quiet     = (issued == IW'(TOTAL_WORDS)) && (resv == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            issued <= IW'(TOTAL_WORDS);
            base_q <= '0;
            resv   <= '0;
            cnt    <= '0;
            wp     <= '0;
            rp     <= '0;
        end else begin
            if (frame_start) begin
                issued <= '0;
                base_q <= base_in;
            end else if (req_acc) begin
                issued <= issued + IW'(BURST);
            end
            resv <= resv + (req_acc ? CW'(BURST) : CW'(0)) - (pop ? CW'(1) : CW'(0));
            cnt  <= cnt + (rsp_valid ? CW'(1) : CW'(0)) - (pop ? CW'(1) : CW'(0));
            if (rsp_valid) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop)       rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rsp_valid) store[wp] <= rsp_data;
    end

    // R5: a pending request holds its address until accepted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R5: reserved space means returned data always finds room
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (32'(cnt) < DEPTH));

    // R7: the emitter never pops a word that is not there
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> avail);

endmodule

// File: rtl/fbscan_emit.sv
module fbscan_emit
    import fbscan_pkg::*;
#(
    parameter int MEM_W    = 128,
    parameter int FRAME_W  = 800,
    parameter int FRAME_H  = 600,
    parameter int PPW      = 4,
    parameter int TOTAL_PX = 480000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             quiet,
    output logic             frame_start,
    input  logic [MEM_W-1:0] head,
    input  logic             avail,
    output logic             pop,
    output logic             pix_valid,
    input  logic             pix_ready,
    output pix_beat_t        beat,
    output logic             uflow,
    output logic [15:0]      line,
    output logic             active
);

    localparam int XW = $clog2(FRAME_W);
    localparam int YW = $clog2(FRAME_H);
    localparam int SW = (PPW > 1) ? $clog2(PPW) : 1;
    localparam int KW = $clog2(TOTAL_PX + 1);

    frame_state_e  state;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic [SW-1:0] slot;
    logic [KW-1:0] skip;

    logic run, take, have_px, discard, use_px, consume, last_px;
    logic [PIX_BITS-1:0] slot_px;

    assign run         = (state == FR_RUN);
    assign take        = run && pix_ready;
    assign have_px     = avail && (skip == '0);
    assign discard     = avail && (skip != '0);
    assign use_px      = take && have_px;
    assign consume     = use_px || discard;
    assign uflow       = take && !have_px;
    assign pop         = consume && (slot == SW'(PPW - 1));
    assign frame_start = !run && quiet && en;
    assign last_px     = (x == XW'(FRAME_W - 1)) && (y == YW'(FRAME_H - 1));
    assign slot_px     = head[int'(slot) * PIX_BITS +: PIX_BITS];

    assign pix_valid = run;
    assign beat.px   = have_px ? slot_px : '0;
    assign beat.sof  = run && (x == '0) && (y == '0);
    assign beat.eol  = run && (x == XW'(FRAME_W - 1));
    assign line      = 16'(y);
    assign active    = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_WAIT;
            x     <= '0;
            y     <= '0;
            slot  <= '0;
            skip  <= '0;
        end else begin
            if (frame_start) begin
                state <= FR_RUN;
                x     <= '0;
                y     <= '0;
            end else if (take) begin
                if (x == XW'(FRAME_W - 1)) begin
                    x <= '0;
                    y <= (y == YW'(FRAME_H - 1)) ? '0 : y + YW'(1);
                end else begin
                    x <= x + XW'(1);
                end
                if (last_px) state <= FR_WAIT;
            end
            if (consume) slot <= (slot == SW'(PPW - 1)) ? '0 : slot + SW'(1);
            skip <= skip + KW'(uflow) - KW'(discard);
        end
    end

    // R4: end-of-line marks are never adjacent on accepted pixels
    a_r4_eol_spacing: assert property (@(posedge clk) disable iff (rst)
        take && beat.eol |=> !beat.eol);

    // R6: a frame start presents pixel 0 of line 0 next
    a_r6_sof_after_start: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> pix_valid && beat.sof);

    // R9: a frame only begins while enabled
    a_r9_start_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(en));

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
    import fbscan_pkg::*;
#(
    parameter int FRAME_W     = 800,
    parameter int FRAME_H     = 600,
    parameter int MEM_W       = 128,
    parameter int CHAN_BITS   = 8,
    parameter int BURST_WORDS = 8,
    parameter int FIFO_WORDS  = 2 * BURST_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [6:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [31:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [MEM_W-1:0] mem_rsp_data,
    output logic             pix_valid,
    input  logic             pix_ready,
    output logic [31:0]      pix_data,
    output logic             pix_sof,
    output logic             pix_eol,
    output logic [15:0]      pix_rgb565
);

    localparam int PPW         = MEM_W / PIX_BITS;
    localparam int TOTAL_PX    = FRAME_W * FRAME_H;
    localparam int TOTAL_WORDS = TOTAL_PX / PPW;

    if (MEM_W < PIX_BITS || MEM_W % PIX_BITS != 0) begin : g_bad_word
        $error("memory word width must be a multiple of 32 bits");
    end
    if (CHAN_BITS != 8) begin : g_bad_chan
        $error("only 8 bits per colour channel are supported");
    end
    if (TOTAL_PX % PPW != 0 || TOTAL_WORDS % BURST_WORDS != 0) begin : g_bad_frame
        $error("frame must divide into whole words and bursts");
    end
    if (FIFO_WORDS < 2 * BURST_WORDS) begin : g_bad_fifo
        $error("prefetch FIFO must hold at least two bursts");
    end

    scan_cfg_t   cfg;
    pix_beat_t   beat;
    logic        frame_start, quiet, avail, pop, uflow, active;
    logic [15:0] line;
    logic [MEM_W-1:0] head;

    fbscan_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .cfg    (cfg),
        .uflow  (uflow),
        .line   (line),
        .active (active)
    );

    fbscan_fetch #(
        .MEM_W       (MEM_W),
        .BURST       (BURST_WORDS),
        .DEPTH       (FIFO_WORDS),
        .TOTAL_WORDS (TOTAL_WORDS)
    ) i_fetch (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .base_in     (cfg.base),
        .req_valid   (mem_req_valid),
        .req_ready   (mem_req_ready),
        .req_addr    (mem_req_addr),
        .rsp_valid   (mem_rsp_valid),
        .rsp_data    (mem_rsp_data),
        .pop         (pop),
        .head        (head),
        .avail       (avail),
        .quiet       (quiet)
    );

    fbscan_emit #(
        .MEM_W    (MEM_W),
        .FRAME_W  (FRAME_W),
        .FRAME_H  (FRAME_H),
        .PPW      (PPW),
        .TOTAL_PX (TOTAL_PX)
    ) i_emit (
        .clk         (clk),
        .rst         (rst),
        .en          (cfg.en),
        .quiet       (quiet),
        .frame_start (frame_start),
        .head        (head),
        .avail       (avail),
        .pop         (pop),
        .pix_valid   (pix_valid),
        .pix_ready   (pix_ready),
        .beat        (beat),
        .uflow       (uflow),
        .line        (line),
        .active      (active)
    );

    assign pix_data   = beat.px;
    assign pix_sof    = beat.sof;
    assign pix_eol    = beat.eol;
    assign pix_rgb565 = to_rgb565(beat.px);

endmodule

// File: tb/test_fbscan_top.sv
`timescale 1ns/1ps
module test_fbscan_top;

    localparam int W    = 8;
    localparam int H    = 3;
    localparam int MW   = 128;
    localparam int BW   = 2;
    localparam int TOT  = W * H;
    localparam int REQS = TOT / (MW / 32) / BW;
    localparam logic [31:0] B1 = 32'h0001_0000;
    localparam logic [31:0] B2 = 32'h0004_0200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [MW-1:0] mem_rsp_data = '0;
    logic pix_valid, pix_ready = 1'b0;
    logic [31:0] pix_data;
    logic pix_sof, pix_eol;
    logic [15:0] pix_rgb565;

    always #2 clk = ~clk;

    fbscan_top #(.FRAME_W(W), .FRAME_H(H), .MEM_W(MW), .BURST_WORDS(BW)) i_fbscan_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_rgb565(pix_rgb565));

    int nchk = 0, nfail = 0, cyc = 0;
    int p = 0, frames = 0, req_k = 0, reqs = 0, blacks = 0, gap = 20, beats = 0;
    int rdy_mode = 0;
    bit mem_hold = 0, hold_rdy = 0, uf_ok = 0, seen_b2 = 0, done = 0;
    logic [31:0] wr_base = '0, req_base = '0, pix_base = '0, cur_addr = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] aq[$];

    function automatic logic [31:0] pxv(input logic [31:0] a);
        return ((a * 32'h9E37_79B1) ^ 32'h5A5A_1234) | 32'h0100_0000;
    endfunction

    function automatic logic [15:0] r565(input logic [31:0] v);
        return {v[23:19], v[15:10], v[7:3]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // memory model, stream sink and checker
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_rsp_valid = 1'b0;
        if (!rst && !mem_hold) begin
            if (beats > 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = {pxv(cur_addr + 12), pxv(cur_addr + 8), pxv(cur_addr + 4), pxv(cur_addr)};
                cur_addr += MW / 8;
                beats--;
            end else if (aq.size() > 0) begin
                cur_addr = aq.pop_front();
                beats = BW;
            end
        end
        mem_req_ready = (cyc % 3) != 2;
        pix_ready = (gap == 0) && !hold_rdy && (rdy_mode == 0 || lfsr[1:0] != 2'b00);
        #1;
        if (!rst) begin
            if (mem_req_valid && mem_req_ready) begin
                if (req_k == 0) req_base = wr_base;
                chk(mem_req_addr == req_base + req_k * BW * (MW / 8), "R5 request address",
                    mem_req_addr, req_base + req_k * BW * (MW / 8));
                aq.push_back(mem_req_addr);
                req_k = (req_k + 1) % REQS;
                reqs++;
            end
            if (pix_valid && pix_ready) begin
                logic [31:0] e;
                if (p == 0) begin
                    pix_base = req_base;
                    if (req_base == B2) seen_b2 = 1;
                end
                e = pxv(pix_base + 4 * p);
                chk(pix_sof == (p == 0), "R4 sof", 32'(pix_sof), 32'(p == 0));
                chk(pix_eol == (p % W == W - 1), "R4 eol", 32'(pix_eol), 32'(p % W == W - 1));
                if (uf_ok && pix_data == 0) begin
                    blacks++;
                    chk(pix_rgb565 == 0, "R7 black rgb565", 32'(pix_rgb565), 0);
                end else begin
                    chk(pix_data == e, "R2 pixel data", pix_data, e);
                    chk(pix_rgb565 == r565(e), "R3 rgb565", 32'(pix_rgb565), 32'(r565(e)));
                end
                if (p == TOT - 1) begin p = 0; frames++; end
                else p++;
            end
            if (!pix_valid) gap = 20;
            else if (gap > 0) gap--;
        end
    end

    initial begin
        wait (cyc > 60000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int f0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk(pix_valid == 0, "R1 pix_valid after reset", 32'(pix_valid), 0);
        chk(mem_req_valid == 0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 0);
        rd(7'h08, d); chk(d == 0, "R1 status after reset", d, 0);
        rd(7'h00, d); chk(d == 0, "R1 control after reset", d, 0);

        wr_base = B1;
        wr(7'h04, B1);
        wr(7'h00, 32'h1);
        rd(7'h04, d); chk(d == B1, "R8 base readback", d, B1);
        rd(7'h00, d); chk(d == 1, "R8 control readback", d, 1);

        // R2 R4 R6: back-to-back frames with an always-ready sink
        while (frames < 2) @(negedge clk);
        // random sink, base changed in the middle of a frame (R6)
        rdy_mode = 1;
        while (!(frames >= 3 && p == W + 2)) @(negedge clk);
        wr_base = B2;
        wr(7'h04, B2);
        while (frames < 5) @(negedge clk);
        chk(seen_b2, "R6 new base used by a later frame", 32'(seen_b2), 1);

        // R8 line number while the sink is stalled
        while (p != 2 * W + 1) @(negedge clk);
        hold_rdy = 1;
        repeat (3) @(negedge clk);
        rd(7'h08, d);
        chk(d[15:0] == 16'(p / W), "R8 status line", 32'(d[15:0]), p / W);
        chk(d[16] == 1'b1, "R8 status active", 32'(d[16]), 1);
        chk(d[17] == 1'b0, "R8 no underflow yet", 32'(d[17]), 0);
        hold_rdy = 0;

        // R7 underflow: stall memory data while the sink keeps pulling
        uf_ok = 1;
        rdy_mode = 0;
        while (p != W) @(negedge clk);
        mem_hold = 1;
        repeat (40) @(negedge clk);
        mem_hold = 0;
        f0 = frames;
        while (frames < f0 + 2) @(negedge clk);
        chk(blacks > 0, "R7 black pixels seen", blacks, 1);
        rd(7'h08, d); chk(d[17] == 1'b1, "R7 sticky underflow set", 32'(d[17]), 1);
        wr(7'h08, 32'h0002_0000);
        rd(7'h08, d); chk(d[17] == 1'b0, "R8 sticky cleared", 32'(d[17]), 0);
        uf_ok = 0;
        f0 = frames;
        while (frames < f0 + 1) @(negedge clk);

        // R9 disable mid-frame: the frame completes, then all stops
        while (p != 5) @(negedge clk);
        wr(7'h00, 32'h0);
        f0 = frames;
        while (frames < f0 + 1) @(negedge clk);
        r0 = reqs;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #2;
            chk(pix_valid == 0, "R9 stream idle after disable", 32'(pix_valid), 0);
        end
        chk(reqs == r0, "R9 no requests after disable", reqs, r0);
        chk(frames == f0 + 1, "R9 frame completed", frames, f0 + 1);
        rd(7'h08, d); chk(d[16] == 1'b0, "R9 active flag cleared", 32'(d[16]), 0);

        // re-enable: next frame from the current base (R6)
        wr(7'h00, 32'h1);
        f0 = frames;
        while (frames < f0 + 1) @(negedge clk);
        chk(pix_base == B2, "R6 frame after re-enable uses base", pix_base, B2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule